// File: doc/BRIEF.md
# Four-Channel Square and Noise Sound Generator

This block produces the digital levels for three square-wave tone voices and one pseudo-random noise voice. Software programs it over a single byte-wide write port. A byte with its top bit set opens a register. It picks one of four channels and either that channel's attenuation or its frequency word, and it carries four data bits. A byte with the top bit clear extends the tone period last opened with six more significant bits. The data byte may be sent again and again to retune the same voice without a fresh register byte.

A prescaler derives a base tick from the system clock. Each tone voice runs a 10-bit down-counter on that tick and flips its square output once per period. The noise voice shifts a 16-bit feedback register at one of three fixed divisions of the tick, or on every rising edge of tone voice 2. Its feedback is set for either a periodic pattern or white noise. Every voice's square bit is gated by a level taken from a 16-entry attenuation table, and the four levels are summed into one mix output.

Top module: `psg_core`

## Requirements
- R1: After reset all four attenuations are 15, so every level output and the mix are 0. All tone outputs and the noise output are 0.
- R2: A byte of the form 1,c1,c0,1,a3..a0 sets the attenuation of channel c (0 to 2 are tones, 3 is noise) to a from the next clock edge. The channel's level output is then LUT[a] while its wave bit (`wave_o[c]`) is 1, and 0 while it is 0.
- R3: The LUT gives 0 for attenuation 15, and 2^LW-1 (255 at LW=8) for attenuation 0. Each entry k in 1..14 is floor(entry(k-1)*203/256): 255,202,160,126,99,78,61,48,38,30,23,18,14,11,8,0.
- R4: A byte 1,c1,c0,0,f3..f0 with c<3 sets bits 3..0 of tone c's period N. A following byte 0,x,h5..h0 sets bits 9..4. Once the counter next reloads, the tone's output flips every N ticks for N>=1, and one tick lasts PRESCALE clocks.
- R5: A tone period of 0 makes the output flip on every tick, the highest rate, the same as a period of 1.
- R6: A data byte (bit 7 clear) with no new register byte in front of it replaces the high six bits of the tone period last selected. The low four bits are kept, and a repeat of the data byte retunes the voice again.
- R7: A data byte that follows an attenuation register byte, or a noise register byte, changes no tone period.
- R8: A byte 1,1,1,0,x,w,r1,r0 writes the noise control and resets the noise register to only its top bit set, which makes the noise output 0. The shift rate r=0,1,2 gives one shift per 16, 32 or 64 ticks counted from that write.
- R9: With w=0 (periodic) the noise output is the low bit of a register that rotates right, so it is 1 for one shift out of every 16.
- R10: With w=1 (white) the bit shifted in at the top is bit 0 XOR bit 3 of the register, and the output is bit 0.
- R11: With r=3 the noise register shifts once on each rising edge of tone 2's output.
- R12: The mix output equals the sum of the four level outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Register or data byte |
| wave_o | output | 4 | Raw square bits, tones 0..2 then noise in bit 3 |
| level_o | output | 4*LW | Attenuated level per channel, channel c in bits c*LW upward |
| mix_o | output | LW+2 | Sum of the four levels |

## Verification
A write lands at the clock edge that samples it. Attenuation, level and mix follow with no further delay, so the bench checks them at the next falling edge. Tone and noise timing depends on where the free-running prescaler stands, so the bench measures gaps between output edges in clocks rather than absolute times. It skips the first partial interval after retuning. For white noise the bench finds the first output change, then samples the middle of each later shift interval and compares against its own model of the register.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int NUM_TONE = 3;
  localparam int NUM_CH   = 4;
  localparam int ATT_W    = 4;

  typedef enum logic [1:0] {
    RATE_16    = 2'd0,
    RATE_32    = 2'd1,
    RATE_64    = 2'd2,
    RATE_TONE2 = 2'd3
  } noise_rate_e;

  typedef struct packed {
    logic        white;
    noise_rate_e rate;
  } noise_ctl_t;
endpackage

// File: rtl/snd_regfile.sv
module snd_regfile
  import snd_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [7:0]                wr_data_i,
  output logic [NUM_TONE*PW-1:0]    period_o,
  output logic [NUM_CH*ATT_W-1:0]   atten_o,
  output noise_ctl_t                nctl_o,
  output logic                      nctl_wr_o
);
  localparam int HI_W = PW - 4;

  logic [PW-1:0]    period_q [NUM_TONE];
  logic [PW-1:0]    period_d [NUM_TONE];
  logic [ATT_W-1:0] atten_q  [NUM_CH];
  logic [ATT_W-1:0] atten_d  [NUM_CH];
  noise_ctl_t       nctl_q, nctl_d;
  logic [1:0]       sel_ch_q, sel_ch_d;
  logic             sel_vol_q, sel_vol_d;
  logic             nctl_wr;

  always_comb begin
    period_d  = period_q;
    atten_d   = atten_q;
    nctl_d    = nctl_q;
    sel_ch_d  = sel_ch_q;
    sel_vol_d = sel_vol_q;
    nctl_wr   = 1'b0;
    if (wr_en_i) begin
      if (wr_data_i[7]) begin
        sel_ch_d  = wr_data_i[6:5];
        sel_vol_d = wr_data_i[4];
        if (wr_data_i[4]) begin
          atten_d[wr_data_i[6:5]] = wr_data_i[3:0];
        end else if (wr_data_i[6:5] == 2'd3) begin
          nctl_d  = noise_ctl_t'(wr_data_i[2:0]);
          nctl_wr = 1'b1;
        end else begin
          for (int i = 0; i < NUM_TONE; i++)
            if (wr_data_i[6:5] == 2'(i)) period_d[i][3:0] = wr_data_i[3:0];
        end
      end else if (!sel_vol_q) begin
        for (int i = 0; i < NUM_TONE; i++)
          if (sel_ch_q == 2'(i)) period_d[i][PW-1:4] = wr_data_i[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TONE; i++) period_q[i] <= '0;
      for (int i = 0; i < NUM_CH; i++)   atten_q[i]  <= '1;
      nctl_q    <= '0;
      sel_ch_q  <= '0;
      sel_vol_q <= 1'b0;
    end else begin
      period_q  <= period_d;
      atten_q   <= atten_d;
      nctl_q    <= nctl_d;
      sel_ch_q  <= sel_ch_d;
      sel_vol_q <= sel_vol_d;
    end
  end

  for (genvar g = 0; g < NUM_TONE; g++) begin : g_per
    assign period_o[g*PW +: PW] = period_q[g];
  end
  for (genvar g = 0; g < NUM_CH; g++) begin : g_att
    assign atten_o[g*ATT_W +: ATT_W] = atten_q[g];
  end
  assign nctl_o    = nctl_q;
  assign nctl_wr_o = nctl_wr;

  // R7: a data byte after an attenuation select leaves every period untouched
  a_r7_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[7] && sel_vol_q) |=> $stable(period_o));

  // R6: a data byte never disturbs the low nibble of any period
  a_r6_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_data_i[7]) |=>
      ($stable(period_q[0][3:0]) && $stable(period_q[1][3:0]) && $stable(period_q[2][3:0])));
endmodule

// File: rtl/snd_tone.sv
module snd_tone #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          wave_o
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          wave_q, wave_d;

  always_comb begin
    cnt_d  = cnt_q;
    wave_d = wave_q;
    if (tick_i) begin
      if (cnt_q <= PW'(1)) begin
        cnt_d  = period_i;
        wave_d = ~wave_q;
      end else begin
        cnt_d = cnt_q - PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;

  // R4: the square output moves only on a tick
  a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(wave_q));

  // R4: a tick that finds the count above one leaves the output alone
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q > PW'(1)) |=> $stable(wave_q));
endmodule

// File: rtl/snd_noise.sv
module snd_noise
  import snd_pkg::*;
#(
  parameter int LFSR_W     = 16,
  parameter int TAP        = 3,
  parameter int BASE_SHIFT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ctl_wr_i,
  input  noise_ctl_t ctl_i,
  input  logic       tone2_i,
  output logic       noise_o
);
  localparam int               DIV_W = BASE_SHIFT + 2;
  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [DIV_W-1:0]  div_q, div_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              t2_q;
  logic [DIV_W-1:0]  mask;
  logic              shift_en;
  logic              fb;

  always_comb begin
    case (ctl_i.rate)
      RATE_16: mask = DIV_W'((1 << BASE_SHIFT) - 1);
      RATE_32: mask = DIV_W'((1 << (BASE_SHIFT + 1)) - 1);
      default: mask = DIV_W'((1 << (BASE_SHIFT + 2)) - 1);
    endcase
    if (ctl_i.rate == RATE_TONE2) shift_en = tone2_i && !t2_q;
    else                          shift_en = tick_i && ((div_q & mask) == mask);
    fb = ctl_i.white ? (lfsr_q[0] ^ lfsr_q[TAP]) : lfsr_q[0];
  end

  always_comb begin
    div_d  = tick_i ? div_q + DIV_W'(1) : div_q;
    lfsr_d = shift_en ? {fb, lfsr_q[LFSR_W-1:1]} : lfsr_q;
    if (ctl_wr_i) begin
      div_d  = '0;
      lfsr_d = SEED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      lfsr_q <= SEED;
      t2_q   <= 1'b0;
    end else begin
      div_q  <= div_d;
      lfsr_q <= lfsr_d;
      t2_q   <= tone2_i;
    end
  end

  assign noise_o = lfsr_q[0];

  // R8: a control write leaves the register at the single-bit seed
  a_r8_seed: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_i |=> (lfsr_q == SEED));

  // R8: without a shift or control write the register holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !ctl_wr_i) |=> $stable(lfsr_q));

  // R10: the register can never lock up at all zeros
  a_r10_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/snd_level.sv
module snd_level
  import snd_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [ATT_W-1:0] atten_i,
  input  logic             on_i,
  output logic [LW-1:0]    level_o
);
  localparam int STEPS = 1 << ATT_W;

  function automatic logic [STEPS*LW-1:0] build_lut();
    logic [STEPS*LW-1:0] t;
    longint              v;
    t = '0;
    v = (longint'(1) << LW) - 1;
    for (int k = 0; k < STEPS - 1; k++) begin
      t[k*LW +: LW] = LW'(v);
      v = (v * 203) >>> 8;
    end
    return t;
  endfunction

  localparam logic [STEPS*LW-1:0] LUT = build_lut();

  assign level_o = on_i ? LUT[atten_i*LW +: LW] : '0;
endmodule

// File: rtl/psg_core.sv
module psg_core
  import snd_pkg::*;
#(
  parameter int PRESCALE = 16,
  parameter int PW       = 10,
  parameter int LW       = 8,
  parameter int LFSR_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_data,
  output logic [NUM_CH-1:0]    wave_o,
  output logic [NUM_CH*LW-1:0] level_o,
  output logic [LW+1:0]        mix_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PS_W-1:0]            pre_q, pre_d;
  logic                       tick;
  logic [NUM_TONE*PW-1:0]     period;
  logic [NUM_CH*ATT_W-1:0]    atten;
  noise_ctl_t                 nctl;
  logic                       nctl_wr;

  assign tick = (pre_q == PS_W'(PRESCALE - 1));

  always_comb begin
    pre_d = tick ? '0 : pre_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  snd_regfile #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .period_o(period), .atten_o(atten), .nctl_o(nctl), .nctl_wr_o(nctl_wr)
  );

  for (genvar g = 0; g < NUM_TONE; g++) begin : g_tone
    snd_tone #(.PW(PW)) u_tone (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .period_i(period[g*PW +: PW]), .wave_o(wave_o[g])
    );
  end

  snd_noise #(.LFSR_W(LFSR_W)) u_noise (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctl_wr_i(nctl_wr),
    .ctl_i(nctl), .tone2_i(wave_o[2]), .noise_o(wave_o[3])
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    snd_level #(.LW(LW)) u_lvl (
      .atten_i(atten[g*ATT_W +: ATT_W]), .on_i(wave_o[g]),
      .level_o(level_o[g*LW +: LW])
    );

    // R2: a channel whose wave bit is low contributes nothing
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !wave_o[g] |-> (level_o[g*LW +: LW] == '0));

    // R3: the highest attenuation is silent
    a_r3_att_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (atten[g*ATT_W +: ATT_W] == '1) |-> (level_o[g*LW +: LW] == '0));
  end

  always_comb begin
    mix_o = '0;
    for (int i = 0; i < NUM_CH; i++) mix_o = mix_o + (LW+2)'(level_o[i*LW +: LW]);
  end
endmodule

// File: tb/test_psg_core.sv
module test_psg_core;
  localparam int P  = 2;
  localparam int LW = 8;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [7:0]        wr_data;
  logic [3:0]        wave_o;
  logic [4*LW-1:0]   level_o;
  logic [LW+1:0]     mix_o;

  int tests = 0;
  int fails = 0;
  int attv [4];

  psg_core #(.PRESCALE(P), .LW(LW)) i_psg_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wave_o(wave_o), .level_o(level_o), .mix_o(mix_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int lut(input int a);
    int t [16] = '{255,202,160,126,99,78,61,48,38,30,23,18,14,11,8,0};
    return t[a];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // clocks between two qualifying edges of wave_o[idx]
  task automatic edge_gap(input int idx, input bit rise, output int gap);
    int  n;
    bit  seen;
    logic prev;
    n = 0; seen = 0; gap = -1; prev = wave_o[idx];
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      n++;
      if (wave_o[idx] != prev && (!rise || wave_o[idx])) begin
        if (!seen) begin seen = 1; n = 0; end
        else begin gap = n; break; end
      end
      prev = wave_o[idx];
    end
  endtask

  task automatic chk_levels(input string req);
    int sum;
    sum = 0;
    for (int c = 0; c < 4; c++) begin
      int e;
      e = wave_o[c] ? lut(attv[c]) : 0;
      sum += e;
      chk(req, level_o[c*LW +: LW], e);
    end
    chk("R12 mix", mix_o, sum);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int g;
    logic [15:0] m;
    void'($urandom(32'h5eed));
    for (int c = 0; c < 4; c++) attv[c] = 15;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 levels", level_o, 0);
    chk("R1 waves", wave_o, 0);
    chk("R1 mix", mix_o, 0);
    rst_n = 1'b1;

    // R2/R3: channel 0 at loudest, period 0 toggles each tick
    wr(8'h90); attv[0] = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R2 R3 ch0 level att0", level_o[0 +: LW], wave_o[0] ? 255 : 0);
    end
    // R5: period 0 half period is one tick
    edge_gap(0, 0, g); chk("R5 period0 gap", g, P);

    // R4: two-byte period 5 on tone 1
    wr(8'hA5); wr(8'h00);
    edge_gap(1, 0, g); edge_gap(1, 0, g); chk("R4 period5 gap", g, 5*P);
    // R6: data byte alone retunes to 0x15
    wr(8'h01);
    edge_gap(1, 0, g); edge_gap(1, 0, g); chk("R6 period21 gap", g, 21*P);
    wr(8'h02);
    edge_gap(1, 0, g); edge_gap(1, 0, g); chk("R6 repeat period37 gap", g, 37*P);

    // R5: tone 2 period 1 equals period 0 rate
    wr(8'hC1); wr(8'h00);
    edge_gap(2, 0, g); edge_gap(2, 0, g); chk("R5 period1 gap", g, P);

    // R7: attenuation select then data byte, tone 1 unchanged
    wr(8'hB3); attv[1] = 3; wr(8'h3F);
    edge_gap(1, 0, g); edge_gap(1, 0, g); chk("R7 after vol", g, 37*P);
    chk_levels("R2 ch1 att3");
    // R7: noise select then data byte, tone 1 unchanged
    wr(8'hE0); wr(8'h3F);
    edge_gap(1, 0, g); chk("R7 after noise", g, 37*P);

    // R8: control write seeds noise, output 0
    wr(8'hE0);
    chk("R8 seed out", wave_o[3], 0);
    // R9: periodic, rate 16 -> rises 16 shifts apart
    edge_gap(3, 1, g); chk("R9 R8 rate16 periodic", g, 16*16*P);
    wr(8'hE1);
    edge_gap(3, 1, g); chk("R8 rate32 periodic", g, 16*32*P);
    wr(8'hE2);
    edge_gap(3, 1, g); chk("R8 rate64 periodic", g, 16*64*P);

    // R11: follow tone 2 with period 3 -> tone full period 6 ticks
    wr(8'hC3); wr(8'h00);
    wr(8'hE3);
    edge_gap(3, 1, g); chk("R11 tone2 driven", g, 16*6*P);

    // R10: white noise sequence at rate 16
    wr(8'hE4);
    chk("R10 seed out", wave_o[3], 0);
    m = 16'h8000;
    while (m[0] == 1'b0) m = {m[0] ^ m[3], m[15:1]};
    g = 0;
    for (int k = 0; k < 2000 && !wave_o[3]; k++) begin
      @(negedge clk); g++;
    end
    repeat (8*P) @(negedge clk);
    chk("R10 first out", wave_o[3], m[0]);
    for (int j = 0; j < 24; j++) begin
      repeat (16*P) @(negedge clk);
      m = {m[0] ^ m[3], m[15:1]};
      chk("R10 white seq", wave_o[3], m[0]);
    end

    // R2/R12: random attenuation writes with level and mix checks
    for (int it = 0; it < 40; it++) begin
      int ch, a, w;
      ch = int'($urandom % 4);
      a  = int'($urandom % 16);
      wr({1'b1, 2'(ch), 1'b1, 4'(a)});
      attv[ch] = a;
      w = int'($urandom % 5);
      repeat (w) @(negedge clk);
      chk_levels("R2 random");
    end

    // R3: attenuation 15 silences channel 0 in both phases
    wr(8'h9F); attv[0] = 15;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 att15 silent", level_o[0 +: LW], 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule